// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the two timing strobes of a serial port from the system clock. The first is a one-cycle oversampling strobe at sixteen times the bit rate. The second is a one-cycle bit strobe at one sixteenth of that rate. The ratio between the system clock and the oversampling strobe is a 16.6 fixed-point divisor. Its integer part sets the base period in clocks. Its 6-bit fraction makes a share of the periods one clock longer, so that the mean period comes out exact. To pick a divisor, take the system clock frequency over sixteen times the wanted baud rate. The fraction field is the fractional remainder times 64, rounded to the nearest whole number.

Software reaches the block through a write-only port with three locations. Two of them hold staged values for the integer part and the fraction. These staged values do nothing on their own. A write to the line-control location copies both into the active divisor in one step and restarts the strobe phase. The generator runs only while `enable` is high and the active integer part is nonzero.

The sequencer is a three-state machine:
- **HALT**: idle. It holds the period counter and the fraction accumulator at zero.
- **RUN**: counts the integer part of the period.
- **EXTRA**: inserts the one stretch clock of a long period.

Its transitions are:
- **start** (HALT to RUN): `enable` is high and the integer part is nonzero.
- **count** (RUN to RUN): an ordinary clock within the period.
- **stretch** (RUN to EXTRA): the fraction add at the end of the period carries out.
- **close** (EXTRA to RUN): the long period ends.
- **stop** (any state to HALT): `enable` falls or the integer part is zero.
- **reload** (any state to RUN): a divisor commit.

Top module: `frac_baud_gen`

## Requirements
- R1: During and after reset both strobes are low, and the active divisor is zero, so no strobe appears until a divisor is committed, even with `enable` high.
- R2: Writes to the integer location (address 0) or the fraction location (address 1) leave the running strobe rate unchanged until a line-control write.
- R3: A write to address 2 (line control, data ignored) commits both staged fields at once, and the new rate applies to the following periods.
- R4: With fraction 0 and integer part N, `tick16_o` pulses exactly every N clocks.
- R5: With fraction F, each oversampling period lasts N or N+1 clocks, and any 64 consecutive periods total exactly 64*N+F clocks.
- R6: For N of 2 or more, `tick16_o` is never high on two consecutive clocks. With N=1 and F=0 it is high on every clock.
- R7: `bit_tick_o` pulses only together with `tick16_o`, once for every 16 oversampling strobes.
- R8: While `enable` is low, both strobes stay low. Strobes resume at the committed rate once `enable` returns high.
- R9: An active integer part of 0 holds both strobes low, whatever the fraction.
- R10: Address 0 takes `wr_data[15:0]` as the integer part. Address 1 takes `wr_data[5:0]` as the fraction and ignores the upper bits. Address 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register location: 0 integer, 1 fraction, 2 line control |
| wr_data | input | 16 | Write data |
| tick16_o | output | 1 | One-cycle oversampling strobe (16x bit rate) |
| bit_tick_o | output | 1 | One-cycle bit strobe (tick16_o / 16) |

## Verification
The bench measures 64-period windows for fractions of 0, 21 and 63. A design that dropped the carry-out stretch, or stretched on the wrong condition, would miss the exact window total even though each single period looks plausible. The bench stages new divisor fields while the generator runs and checks that the old rate persists. A design that let the staged fields through early would change rate before the line-control write. The bench also covers the degenerate divisors 1 and 0 and an `enable` drop. A design that mishandled these would either fuse strobes into a constant level or keep pulsing while it should be silent. Bit strobes are checked for a spacing of exactly 16 oversampling strobes, which catches an off-by-one in the divide-by-16 counter.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 6;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;
    localparam int OVS    = 16;

    localparam logic [ADDR_W-1:0] LOC_INT  = 2'd0;
    localparam logic [ADDR_W-1:0] LOC_FRAC = 2'd1;
    localparam logic [ADDR_W-1:0] LOC_LCR  = 2'd2;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_EXTRA = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fbg_divreg.sv
module fbg_divreg
    import fbg_pkg::*;
#(
    parameter int IW = INT_W,
    parameter int FW = FRAC_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [IW-1:0] act_int,
    output logic [FW-1:0] act_frac,
    output logic          commit_p
);
    logic [IW-1:0] stg_int;
    logic [FW-1:0] stg_frac;

    // staged fields: written freely, no effect on the generator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_int  <= '0;
            stg_frac <= '0;
        end else if (wr_en) begin
            if (wr_addr == LOC_INT)  stg_int  <= wr_data[IW-1:0];
            if (wr_addr == LOC_FRAC) stg_frac <= wr_data[FW-1:0];
        end
    end

    // active divisor: loaded from the staged fields on a line-control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_int  <= '0;
            act_frac <= '0;
            commit_p <= 1'b0;
        end else begin
            commit_p <= wr_en && (wr_addr == LOC_LCR);
            if (wr_en && (wr_addr == LOC_LCR)) begin
                act_int  <= stg_int;
                act_frac <= stg_frac;
            end
        end
    end

    // R2
    staged_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != LOC_LCR) |=> ($stable(act_int) && $stable(act_frac)));

    // R3
    commit_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LOC_LCR) |=>
            (act_int == $past(stg_int) && act_frac == $past(stg_frac) && commit_p));
endmodule

// File: rtl/fbg_seq.sv
module fbg_seq
    import fbg_pkg::*;
#(
    parameter int IW = INT_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          restart,
    input  logic [IW-1:0] div_int,
    input  logic [FW-1:0] div_frac,
    output logic          tick16_o,
    output logic          halted_o
);
    seq_state_t    st_q, st_d;
    logic [IW-1:0] cnt_q, cnt_d;
    logic [FW-1:0] acc_q, acc_d;
    logic          fire;
    logic          live;
    logic          last;
    logic [FW:0]   sum;

    assign live = enable && (div_int != '0);
    assign last = (cnt_q == div_int - IW'(1));
    assign sum  = {1'b0, acc_q} + {1'b0, div_frac};

    // next-state and strobe decision
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        acc_d = acc_q;
        fire  = 1'b0;
        if (!live) begin
            st_d  = ST_HALT;
            cnt_d = '0;
            acc_d = '0;
        end else if (restart) begin
            st_d  = ST_RUN;
            cnt_d = '0;
            acc_d = '0;
        end else begin
            unique case (st_q)
                ST_HALT: begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end
                ST_RUN: begin
                    if (last) begin
                        acc_d = sum[FW-1:0];
                        cnt_d = '0;
                        if (sum[FW]) st_d = ST_EXTRA;
                        else         fire = 1'b1;
                    end else begin
                        cnt_d = cnt_q + IW'(1);
                    end
                end
                ST_EXTRA: begin
                    fire = 1'b1;
                    st_d = ST_RUN;
                end
                default: st_d = ST_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HALT;
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            acc_q <= acc_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick16_o <= 1'b0;
        else        tick16_o <= fire;
    end

    assign halted_o = (st_q == ST_HALT);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tick16_o);

    // R9
    zero_div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_int == '0) |=> !tick16_o);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16_o && div_int > IW'(1)) |=> !tick16_o);
endmodule

// File: rtl/fbg_bitdiv.sv
module fbg_bitdiv
    import fbg_pkg::*;
#(
    parameter int RATIO = OVS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic halted,
    input  logic restart,
    output logic bit_tick_o
);
    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] TOP = CW'(RATIO - 1);

    logic [CW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ph_q <= '0;
        else if (halted || restart) ph_q <= '0;
        else if (tick16)           ph_q <= (ph_q == TOP) ? '0 : ph_q + CW'(1);
    end

    assign bit_tick_o = tick16 && (ph_q == TOP);

    // R7
    bit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic        tick16_o,
    output logic        bit_tick_o
);
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic              commit_p;
    logic              halted;

    fbg_divreg #(.IW(INT_W), .FW(FRAC_W), .AW(ADDR_W), .DW(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .act_int(act_int), .act_frac(act_frac),
        .commit_p(commit_p)
    );

    fbg_seq #(.IW(INT_W), .FW(FRAC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(commit_p),
        .div_int(act_int), .div_frac(act_frac),
        .tick16_o(tick16_o), .halted_o(halted)
    );

    fbg_bitdiv #(.RATIO(OVS)) u_bit (
        .clk(clk), .rst_n(rst_n), .tick16(tick16_o), .halted(halted),
        .restart(commit_p), .bit_tick_o(bit_tick_o)
    );
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick16_o, bit_tick_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    frac_baud_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .tick16_o(tick16_o), .bit_tick_o(bit_tick_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int ip, input logic [15:0] fdata);
        wr(2'd0, 16'(ip));
        wr(2'd1, fdata);
        wr(2'd2, 16'h00A5);
    endtask

    task automatic count_for(input int n, output int ticks, output int bits);
        ticks = 0; bits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick16_o) ticks++;
            if (bit_tick_o) bits++;
        end
    endtask

    task automatic window(input int n, output int total, output int pmin,
                          output int pmax, output int bits, output int bitbad);
        int cyc = 0, got = 0, since = -1, guard = 0;
        total = 0; pmin = 1000000; pmax = 0; bits = 0; bitbad = 0;
        while (!tick16_o && guard < 5000) begin @(negedge clk); guard++; end
        if (bit_tick_o) since = 0;
        while (got < n && guard < 30000) begin
            @(negedge clk); guard++; cyc++;
            if (bit_tick_o && !tick16_o) bitbad++;
            if (tick16_o) begin
                got++; total += cyc;
                if (cyc < pmin) pmin = cyc;
                if (cyc > pmax) pmax = cyc;
                cyc = 0;
                if (since >= 0) since++;
                if (bit_tick_o) begin
                    bits++;
                    if (since >= 0 && since != 16) bitbad++;
                    since = 0;
                end
            end
        end
        if (got < n) total = -1;
    endtask

    task automatic t_reset;
        int t, b;
        @(negedge clk);
        check(!tick16_o && !bit_tick_o, "R1 strobes in reset", tick16_o, 0);
        rst_n = 1'b1; enable = 1'b1;
        count_for(100, t, b);
        check(t == 0, "R1 no tick16 before commit", t, 0);
        check(b == 0, "R1 no bit tick before commit", b, 0);
    endtask

    task automatic t_integer;
        int tot, mn, mx, b, bb;
        load(5, 16'h0000);
        window(64, tot, mn, mx, b, bb);
        check(tot == 320, "R4 window total N=5", tot, 320);
        check(mn == 5 && mx == 5, "R4 period N=5", mx, 5);
    endtask

    task automatic t_staging;
        int tot, mn, mx, b, bb;
        wr(2'd0, 16'd9);
        wr(2'd1, 16'd10);
        window(32, tot, mn, mx, b, bb);
        check(tot == 160, "R2 staged fields ignored", tot, 160);
        wr(2'd2, 16'h0000);
        window(64, tot, mn, mx, b, bb);
        check(tot == 586, "R3 committed 9+10/64 total", tot, 586);
        check(mn == 9 && mx == 10, "R3 committed period range", mn, 9);
    endtask

    task automatic t_fraction;
        int tot, mn, mx, b, bb;
        load(7, 16'hFFD5);
        window(64, tot, mn, mx, b, bb);
        check(tot == 469, "R5 R10 total 7+21/64", tot, 469);
        check(mn == 7 && mx == 8, "R5 period range 7..8", mx, 8);
        load(3, 16'h003F);
        window(64, tot, mn, mx, b, bb);
        check(tot == 255, "R5 total 3+63/64", tot, 255);
        check(mn >= 3 && mx <= 4, "R5 period range 3..4", mx, 4);
    endtask

    task automatic t_addr3;
        int tot, mn, mx, b, bb;
        wr(2'd3, 16'd2);
        wr(2'd3, 16'h0000);
        window(64, tot, mn, mx, b, bb);
        check(tot == 255, "R10 address 3 writes nothing", tot, 255);
    endtask

    task automatic t_bits;
        int tot, mn, mx, b, bb;
        load(2, 16'h0000);
        window(64, tot, mn, mx, b, bb);
        check(mn == 2 && mx == 2, "R6 N=2 strobes separated", mn, 2);
        check(b == 4, "R7 bit ticks per 64 strobes", b, 4);
        check(bb == 0, "R7 bit tick alignment errors", bb, 0);
    endtask

    task automatic t_unity;
        int tot, mn, mx, b, bb;
        load(1, 16'h0000);
        window(64, tot, mn, mx, b, bb);
        check(tot == 64 && mx == 1, "R6 N=1 strobe every clock", tot, 64);
        check(b == 4 && bb == 0, "R7 bit ticks at N=1", b, 4);
    endtask

    task automatic t_enable;
        int t, b, tot, mn, mx, bb;
        load(4, 16'h0000);
        enable = 1'b0;
        @(negedge clk);
        count_for(100, t, b);
        check(t == 0 && b == 0, "R8 quiet while disabled", t, 0);
        enable = 1'b1;
        window(32, tot, mn, mx, b, bb);
        check(tot == 128, "R8 resume at committed rate", tot, 128);
    endtask

    task automatic t_zero;
        int t, b;
        load(0, 16'd5);
        @(negedge clk);
        count_for(200, t, b);
        check(t == 0 && b == 0, "R9 integer 0 holds strobes low", t, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_integer;
        t_staging;
        t_fraction;
        t_addr3;
        t_bits;
        t_unity;
        t_enable;
        t_zero;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule